// File: doc/BRIEF.md
# Packed-Decimal Byte Arithmetic Unit

This unit does byte-wide arithmetic on packed BCD values, where each byte holds two decimal digits. It runs a binary add or subtract on two operands, with or without the stored carry. It then corrects the binary answer into two valid decimal digits with a separate decimal-adjust operation. A registered flag set records carry, zero, sign, subtract mode and half-carry. The decimal adjust reads the mode, carry and half-carry flags to choose its correction.

One operation runs on each rising clock edge on which the strobe is high. Software-visible state lives only in the result register and the five flags. A decimal adjust acts on the `dst_in` operand. In normal use the enclosing datapath feeds the previous result back into `dst_in`. A binary ADC followed by an adjust gives the decimal sum. An SBC followed by an adjust gives the decimal difference, with the carry flag reporting a decimal carry or borrow.

The unit has no state machine beyond the result and flag registers. The opcode select alone decides each cycle's behaviour. Opcode encoding on `op_sel`: 0 = ADD, 1 = ADC, 2 = SUB, 3 = SBC, 4 = DA, and 5 to 7 are unassigned.

Top module: `bcd_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the result and all five flags are cleared to 0 at that edge.
- R2: At an edge where `op_valid` is low, the result and all flags keep their values.
- R3: ADD (0) stores `dst_in + src_in` modulo 256 and ADC (1) also adds the stored C. C takes the carry out of bit 7 and H the carry out of bit 3. D is cleared.
- R4: SUB (2) stores `dst_in - src_in` modulo 256 and SBC (3) also subtracts the stored C as a borrow. C takes the borrow out of bit 7 and H the borrow out of bit 3. D is set.
- R5: After every operation with opcode 0 to 4, Z is 1 exactly when the new result is 0, and S equals bit 7 of the new result.
- R6: DA (4) with D=0 adds a correction to `dst_in`. The low-nibble part is 06 when H=1 or the low nibble exceeds 9. The high-nibble part is 60 when C=1, when the high nibble exceeds 9, or when the high nibble is 9 and the low nibble exceeds 9. C becomes 1 exactly when the 60 part is applied.
- R7: DA with D=1 adds FA when H=1 and adds A0 when C=1, or 9A when both are 1, all modulo 256. C keeps its prior value.
- R8: DA leaves D and H unchanged.
- R9: For any two BCD bytes and either stored carry, ADC then DA gives the BCD digits of the decimal sum modulo 100, with C set when the sum reaches 100. SBC then DA gives the decimal difference modulo 100, with C set when it borrowed.
- R10: An operation with `op_sel` 5, 6 or 7 leaves the result and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Opcode: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 DA |
| dst_in | input | 8 | Destination operand (also the DA input) |
| src_in | input | 8 | Source operand |
| result | output | 8 | Registered result |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag (result bit 7) |
| flag_d | output | 1 | Subtract-mode flag |
| flag_h | output | 1 | Half-carry / half-borrow flag |

## Verification
The bench sweeps every pair of two-digit decimal operands through ADC and SBC with both stored carry values. Each pair is followed by an adjust, and the result is compared with decimal sums and differences computed in integers.

This sweep covers the corrections that are easy to get wrong:
- A high nibble of 9 paired with an oversized low nibble. A unit that tested only the high nibble would leave an A0-style byte and drop the carry.
- The 99+99+1 case, where both C and H are set on entry.
- Subtraction borrows across both digits. A unit that reused the addition corrections would give wrong differences.

Directed cases check a zero-producing adjust, a negative-signed adjust, idle cycles and unassigned opcodes. Faults there would show as a stale Z or S flag or as a corrupted register.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_DA  = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic d;
        logic h;
    } alu_flags_t;

endpackage

// File: rtl/bcd_binary_core.sv
module bcd_binary_core
    import bcd_alu_pkg::*;
(
    input  logic [BYTE_W-1:0] lhs,
    input  logic [BYTE_W-1:0] rhs,
    input  logic              carry_in,
    input  logic              subtract,
    output logic [BYTE_W-1:0] value,
    output logic              carry_out,
    output logic              half_out
);

    logic [BYTE_W:0] wide;
    logic [NIB_W:0]  low;

    always_comb begin
        if (subtract) begin
            wide = {1'b0, lhs} - {1'b0, rhs} - {{BYTE_W{1'b0}}, carry_in};
            low  = {1'b0, lhs[NIB_W-1:0]} - {1'b0, rhs[NIB_W-1:0]}
                 - {{NIB_W{1'b0}}, carry_in};
        end else begin
            wide = {1'b0, lhs} + {1'b0, rhs} + {{BYTE_W{1'b0}}, carry_in};
            low  = {1'b0, lhs[NIB_W-1:0]} + {1'b0, rhs[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, carry_in};
        end
    end

    // The top bit of the widened sum is a carry for addition and a borrow for subtraction.
    assign value     = wide[BYTE_W-1:0];
    assign carry_out = wide[BYTE_W];
    assign half_out  = low[NIB_W];

endmodule

// File: rtl/bcd_adjust_core.sv
module bcd_adjust_core
    import bcd_alu_pkg::*;
(
    input  logic [BYTE_W-1:0] raw,
    input  logic              c_in,
    input  logic              h_in,
    input  logic              sub_mode,
    output logic [BYTE_W-1:0] fixed,
    output logic              c_out
);

    localparam logic [BYTE_W-1:0] ADD_LO = 8'h06;
    localparam logic [BYTE_W-1:0] ADD_HI = 8'h60;
    localparam logic [BYTE_W-1:0] SUB_LO = 8'hFA;
    localparam logic [BYTE_W-1:0] SUB_HI = 8'hA0;

    logic [NIB_W-1:0]  lo_nib, hi_nib;
    logic              lo_over, hi_over, hi_nine;
    logic              fix_lo, fix_hi;
    logic [BYTE_W-1:0] corr_lo, corr_hi;

    assign lo_nib  = raw[NIB_W-1:0];
    assign hi_nib  = raw[BYTE_W-1:NIB_W];
    assign lo_over = lo_nib > 4'd9;
    assign hi_over = hi_nib > 4'd9;
    assign hi_nine = hi_nib == 4'd9;

    always_comb begin
        if (sub_mode) begin
            // After subtraction only the recorded borrows select a correction.
            fix_lo  = h_in;
            fix_hi  = c_in;
            corr_lo = fix_lo ? SUB_LO : '0;
            corr_hi = fix_hi ? SUB_HI : '0;
        end else begin
            fix_lo  = h_in | lo_over;
            fix_hi  = c_in | hi_over | (hi_nine & lo_over);
            corr_lo = fix_lo ? ADD_LO : '0;
            corr_hi = fix_hi ? ADD_HI : '0;
        end
    end

    assign fixed = raw + corr_lo + corr_hi;
    assign c_out = fix_hi;

endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
    import bcd_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [BYTE_W-1:0] dst_in,
    input  logic [BYTE_W-1:0] src_in,
    output logic [BYTE_W-1:0] result,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_d,
    output logic              flag_h
);

    alu_flags_t        flags_q, flags_d;
    logic [BYTE_W-1:0] result_q, result_d;

    logic              use_carry, is_sub;
    logic [BYTE_W-1:0] bin_value;
    logic              bin_carry, bin_half;
    logic [BYTE_W-1:0] adj_value;
    logic              adj_carry;

    assign use_carry = (op_sel == OP_ADC) || (op_sel == OP_SBC);
    assign is_sub    = (op_sel == OP_SUB) || (op_sel == OP_SBC);

    bcd_binary_core u_bin (
        .lhs       (dst_in),
        .rhs       (src_in),
        .carry_in  (use_carry & flags_q.c),
        .subtract  (is_sub),
        .value     (bin_value),
        .carry_out (bin_carry),
        .half_out  (bin_half)
    );

    bcd_adjust_core u_adj (
        .raw      (dst_in),
        .c_in     (flags_q.c),
        .h_in     (flags_q.h),
        .sub_mode (flags_q.d),
        .fixed    (adj_value),
        .c_out    (adj_carry)
    );

    always_comb begin
        result_d = result_q;
        flags_d  = flags_q;
        unique case (op_sel)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                result_d  = bin_value;
                flags_d.c = bin_carry;
                flags_d.h = bin_half;
                flags_d.d = is_sub;
                flags_d.z = (bin_value == '0);
                flags_d.s = bin_value[BYTE_W-1];
            end
            OP_DA: begin
                result_d  = adj_value;
                flags_d.c = adj_carry;
                flags_d.z = (adj_value == '0);
                flags_d.s = adj_value[BYTE_W-1];
            end
            default: begin
                result_d = result_q;
                flags_d  = flags_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '0;
        end else if (op_valid) begin
            result_q <= result_d;
            flags_q  <= flags_d;
        end
    end

    assign result = result_q;
    assign flag_c = flags_q.c;
    assign flag_z = flags_q.z;
    assign flag_s = flags_q.s;
    assign flag_d = flags_q.d;
    assign flag_h = flags_q.h;

endmodule

// File: rtl/bcd_alu_checker.sv
module bcd_alu_checker (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [2:0] op_sel,
    input logic [7:0] result,
    input logic       flag_c,
    input logic       flag_z,
    input logic       flag_s,
    input logic       flag_d,
    input logic       flag_h
);

    logic [12:0] state_bits;
    assign state_bits = {result, flag_c, flag_z, flag_s, flag_d, flag_h};

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (state_bits == '0));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(state_bits));

    assert_add_clears_mode_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == 3'd0 || op_sel == 3'd1)) |=> !flag_d);

    assert_sub_sets_mode_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == 3'd2 || op_sel == 3'd3)) |=> flag_d);

    assert_zero_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel <= 3'd4) |=> ((flag_z == (result == 8'h00)) && (flag_s == result[7])));

    assert_sub_adjust_carry_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd4 && flag_d) |=> $stable(flag_c));

    assert_adjust_keeps_dh_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd4) |=> ($stable(flag_d) && $stable(flag_h)));

    assert_unused_op_R10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel > 3'd4) |=> $stable(state_bits));

endmodule

bind bcd_alu bcd_alu_checker u_bcd_alu_checker (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .result   (result),
    .flag_c   (flag_c),
    .flag_z   (flag_z),
    .flag_s   (flag_s),
    .flag_d   (flag_d),
    .flag_h   (flag_h)
);

// File: tb/bcd_alu_bench.sv
module bcd_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] dst_in = 8'h00;
    logic [7:0] src_in = 8'h00;
    logic [7:0] result;
    logic       flag_c, flag_z, flag_s, flag_d, flag_h;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_alu u_bcd_alu (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .dst_in(dst_in), .src_in(src_in), .result(result),
        .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s),
        .flag_d(flag_d), .flag_h(flag_h)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample shortly after it.
    task automatic step(input bit v, input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op_valid = v; op_sel = op; dst_in = a; src_in = b;
        @(posedge clk);
        #1;
    endtask

    function automatic int to_bcd(input int n);
        return ((n / 10) << 4) | (n % 10);
    endfunction

    task automatic set_carry(input bit c);
        step(1'b1, 3'd0, c ? 8'hFF : 8'h00, c ? 8'h01 : 8'h00);
    endtask

    // Binary op then decimal adjust, both checked against integer models.
    task automatic run_pair(input int da, input int db, input bit sub, input bit with_c, input bit cin);
        int a, b, ci, raw, ex_res, ex_c, ex_h, dec, dec_c;
        bit keep_d, keep_h;
        a  = to_bcd(da);
        b  = to_bcd(db);
        ci = with_c ? int'(cin) : 0;
        if (with_c) set_carry(cin);
        if (!sub) begin
            raw  = a + b + ci;
            ex_c = (raw > 255) ? 1 : 0;
            ex_h = (((a & 15) + (b & 15) + ci) > 15) ? 1 : 0;
            dec  = da + db + ci;
            dec_c = (dec >= 100) ? 1 : 0;
            dec  = dec % 100;
        end else begin
            raw  = a - b - ci;
            ex_c = (raw < 0) ? 1 : 0;
            ex_h = (((a & 15) - (b & 15) - ci) < 0) ? 1 : 0;
            dec  = da - db - ci;
            dec_c = (dec < 0) ? 1 : 0;
            if (dec < 0) dec += 100;
        end
        ex_res = raw & 255;
        step(1'b1, sub ? (with_c ? 3'd3 : 3'd2) : (with_c ? 3'd1 : 3'd0), a[7:0], b[7:0]);
        if (!sub) begin
            chk("R3 sum", result, ex_res);
            chk("R3 carry", flag_c, ex_c);
            chk("R3 half", flag_h, ex_h);
            chk("R3 mode", flag_d, 0);
        end else begin
            chk("R4 diff", result, ex_res);
            chk("R4 borrow", flag_c, ex_c);
            chk("R4 half", flag_h, ex_h);
            chk("R4 mode", flag_d, 1);
        end
        chk("R5 zero", flag_z, (ex_res == 0) ? 1 : 0);
        keep_d = flag_d;
        keep_h = flag_h;
        step(1'b1, 3'd4, result, 8'h00);
        chk(sub ? "R7 R9 decimal diff" : "R6 R9 decimal sum", result, to_bcd(dec));
        chk("R9 decimal carry", flag_c, dec_c);
        chk("R5 zero after adjust", flag_z, (dec == 0) ? 1 : 0);
        chk("R5 sign after adjust", flag_s, (to_bcd(dec) >> 7) & 1);
        chk("R8 mode kept", flag_d, keep_d);
        chk("R8 half kept", flag_h, keep_h);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset result", result, 0);
        chk("R1 reset flags", {flag_c, flag_z, flag_s, flag_d, flag_h}, 0);
        @(negedge clk);
        rst = 1'b0;

        // R5 zero after adjust: 50+50 -> A0, adjust adds 60 -> 00 with C set.
        step(1'b1, 3'd0, 8'h50, 8'h50);
        step(1'b1, 3'd4, result, 8'h00);
        chk("R6 zero adjust result", result, 8'h00);
        chk("R6 zero adjust carry", flag_c, 1);
        chk("R5 zero adjust Z", flag_z, 1);

        // R5 sign: 45+45 -> 8A, adjust adds 06 -> 90.
        step(1'b1, 3'd0, 8'h45, 8'h45);
        step(1'b1, 3'd4, result, 8'h00);
        chk("R6 low fix result", result, 8'h90);
        chk("R5 sign set", flag_s, 1);
        chk("R6 low fix carry", flag_c, 0);

        // R6 high nibble 9 with oversized low nibble: 9A -> 00, C=1.
        step(1'b1, 3'd0, 8'h49, 8'h51);
        step(1'b1, 3'd4, result, 8'h00);
        chk("R6 nine-high result", result, 8'h00);
        chk("R6 nine-high carry", flag_c, 1);

        // R2: strobe low with changing inputs leaves state alone.
        step(1'b1, 3'd0, 8'h12, 8'h34);
        step(1'b0, 3'd2, 8'hFF, 8'h01);
        chk("R2 idle result", result, 8'h46);
        chk("R2 idle flags", {flag_c, flag_z, flag_s, flag_d, flag_h}, 5'b00000);

        // R10: unassigned opcodes leave state alone.
        for (int k = 5; k < 8; k++) begin
            step(1'b1, 3'(k), 8'hFF, 8'hFF);
            chk("R10 unused op result", result, 8'h46);
            chk("R10 unused op flags", {flag_c, flag_z, flag_s, flag_d, flag_h}, 5'b00000);
        end

        // R7: 00-01 -> FF, C=1 H=1, adjust adds 9A -> 99, C stays 1.
        step(1'b1, 3'd2, 8'h00, 8'h01);
        step(1'b1, 3'd4, result, 8'h00);
        chk("R7 both borrows result", result, 8'h99);
        chk("R7 both borrows carry", flag_c, 1);

        // Full decimal sweep with carry and borrow, both stored carries.
        for (int x = 0; x < 100; x++) begin
            for (int y = 0; y < 100; y++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    run_pair(x, y, 1'b0, 1'b1, ci[0]);
                    run_pair(x, y, 1'b1, 1'b1, ci[0]);
                end
            end
        end
        // Plain ADD and SUB on a spread of pairs.
        for (int x = 0; x < 100; x += 3) begin
            for (int y = 0; y < 100; y += 3) begin
                run_pair(x, y, 1'b0, 1'b0, 1'b0);
                run_pair(x, y, 1'b1, 1'b0, 1'b0);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule